// File: doc/BRIEF.md
# Dual-Channel UART Host Register Front End

This block is the host side of a two-channel, 16550-style serial controller. A host reaches it over a byte-wide bus with asynchronous strobes: an active-low chip select, an active-low read strobe, an active-low write strobe, three register address lines and a channel-select line. The block keeps a small register set for each channel: the two divisor latch bytes, the line control byte, an alternate-function byte, a modem-output byte and a scratch byte. It returns read data on one shared byte bus. Serial shifters, FIFOs, baud counting and interrupts lie outside this block.

Both strobes pass through a two-stage synchronizer into the system clock, so no bus access needs the baud clock. A write takes effect when its strobe deasserts. Read data is captured once the synchronized read strobe falls, and it holds until the next qualified read. The bus is a plain strobe bus with no valid/ready handshake. The host must therefore keep chip select, channel select, address and write data steady from the strobe's falling edge until three clock periods after its rising edge. Addresses 0 to 4 and 7 keep their customary positions. When both divisor bytes of a channel are zero, the divisor addresses return a fixed device identification byte and a fixed revision byte.

Each channel drives one active-low multifunction output. Two alternate-function bits choose what it carries: the general-purpose output bit, the baud tick, the receive-ready status, or a constant inactive level.

Top module: `duart_host_regs`

## Requirements
- R1: An access takes effect only when `bus_cs_n` is low. `bus_chsel` = 0 selects channel A and 1 selects channel B. A write with `bus_cs_n` high changes no register, and a read with `bus_cs_n` high leaves `bus_rdata` unchanged.
- R2: A write is committed at the third rising clock edge after `bus_wr_n` rises. The multifunction pin reflects the new register value one edge later.
- R3: Address 3 is line control, address 4 is modem output (bit 3 is the general-purpose output bit), and address 7 is scratch. Each reads back the value last written. Addresses 5 and 6 read 0x00 and ignore writes.
- R4: Read data is loaded at the third rising clock edge after `bus_rd_n` falls. It stays unchanged while the synchronized strobe remains low, and after that until the next qualified read.
- R5: When line control bit 7 is 1, address 0 is the divisor low byte and address 1 is the divisor high byte. When bit 7 is 0, those two addresses read 0x00 and ignore writes.
- R6: The alternate-function byte sits at address 2 only while line control equals 0xBF. At any other time, address 2 reads 0x00 and writes to it are ignored.
- R7: If both divisor bytes of a channel are 0x00, a read of address 1 returns 0x02 and a read of address 0 returns 0x01. Otherwise the stored divisor bytes are returned.
- R8: When alternate-function bits [2:1] are 2'b00, `mf_n` carries the inverse of modem-output bit 3. When they are 2'b01, `mf_n` carries the inverse of `baud_tick`. Each case has one clock of latency.
- R9: When alternate-function bits [2:1] are 2'b10, `mf_n` carries the inverse of `rx_ready`, with one clock of latency.
- R10: When alternate-function bits [2:1] are 2'b11, `mf_n` is held high.
- R11: Reset clears every register of both channels to 0x00, clears `bus_rdata` to 0x00 and drives both `mf_n` bits high.
- R12: A write to one channel leaves every register of the other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high reset for both channels |
| bus_cs_n | input | 1 | Active-low chip select |
| bus_chsel | input | 1 | Channel select (0 = A, 1 = B) |
| bus_rd_n | input | 1 | Active-low read strobe |
| bus_wr_n | input | 1 | Active-low write strobe |
| bus_addr | input | 3 | Register address within the channel |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, held between reads |
| baud_tick | input | 2 | Per-channel baud tick from the baud generator |
| rx_ready | input | 2 | Per-channel receive-ready status |
| mf_n | output | 2 | Per-channel active-low multifunction output |

## Verification
Some rules can be checked on every cycle, and the bound checker does so. It checks that each multifunction output follows its selected source one clock later and stays high in the reserved setting. It checks that line control changes only after a synchronized write edge, that the alternate-function field changes only while line control holds the access key, and that read data does not move while the synchronized read strobe stays low. Other behaviour needs a directed bus sequence, so the bench covers it with scenarios. These include the identification and revision bytes, the hiding of divisor and alternate-function registers, the exact commit and load cycles, channel isolation, ignored chip-deselected accesses and a mid-run reset. The bench also compares the multifunction pins against its own model on every cycle.

// File: rtl/duart_host_pkg.sv
package duart_host_pkg;
  localparam int DW = 8;
  localparam int AW = 3;

  typedef logic [DW-1:0] byte_t;
  typedef logic [AW-1:0] addr_t;

  typedef struct packed {
    byte_t div_lo;
    byte_t div_hi;
    byte_t line_ctl;
    byte_t alt_fn;
    byte_t modem_out;
    byte_t scratch;
  } chan_regs_t;

  localparam addr_t ADR_DIV_LO = 3'd0;
  localparam addr_t ADR_DIV_HI = 3'd1;
  localparam addr_t ADR_ALT    = 3'd2;
  localparam addr_t ADR_LINE   = 3'd3;
  localparam addr_t ADR_MODEM  = 3'd4;
  localparam addr_t ADR_SCR    = 3'd7;

  localparam byte_t ALT_KEY   = 8'hBF;
  localparam int    DIV_EN_BIT = 7;
  localparam int    GPO_BIT    = 3;
  localparam int    SEL_LSB    = 1;

  typedef enum logic [1:0] {
    MF_GPO   = 2'b00,
    MF_BAUD  = 2'b01,
    MF_RXRDY = 2'b10,
    MF_IDLE  = 2'b11
  } mf_sel_e;

  function automatic byte_t read_mux(chan_regs_t r, addr_t a, byte_t id_code, byte_t rev_code);
    byte_t d;
    logic  div_zero;
    div_zero = (r.div_lo == '0) && (r.div_hi == '0);
    d = '0;
    case (a)
      ADR_DIV_LO: if (r.line_ctl[DIV_EN_BIT]) d = div_zero ? rev_code : r.div_lo;
      ADR_DIV_HI: if (r.line_ctl[DIV_EN_BIT]) d = div_zero ? id_code : r.div_hi;
      ADR_ALT:    if (r.line_ctl == ALT_KEY) d = r.alt_fn;
      ADR_LINE:   d = r.line_ctl;
      ADR_MODEM:  d = r.modem_out;
      ADR_SCR:    d = r.scratch;
      default:    d = '0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/duart_strobe_sync.sv
module duart_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n,
  output logic prev_n,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] shreg;
  logic            level_n;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) shreg <= '1;
    else     shreg <= {shreg[STAGES-1:0], strobe_n};
  end

  assign level_n = shreg[STAGES-1];
  assign prev_n  = shreg[STAGES];
  assign rise    = level_n & ~prev_n;
  assign fall    = ~level_n & prev_n;
endmodule

// File: rtl/duart_chan_regs.sv
module duart_chan_regs
  import duart_host_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  addr_t      addr,
  input  byte_t      wdata,
  output chan_regs_t regs
);
  logic div_open;
  logic alt_open;

  assign div_open = regs.line_ctl[DIV_EN_BIT];
  assign alt_open = (regs.line_ctl == ALT_KEY);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      regs <= '0;
    end else if (wr_en) begin
      case (addr)
        ADR_DIV_LO: if (div_open) regs.div_lo <= wdata;
        ADR_DIV_HI: if (div_open) regs.div_hi <= wdata;
        ADR_ALT:    if (alt_open) regs.alt_fn <= wdata;
        ADR_LINE:   regs.line_ctl  <= wdata;
        ADR_MODEM:  regs.modem_out <= wdata;
        ADR_SCR:    regs.scratch   <= wdata;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/duart_mf_drive.sv
module duart_mf_drive
  import duart_host_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] sel,
  input  logic       gpo,
  input  logic       tick,
  input  logic       rxrdy,
  output logic       mf_n
);
  logic nxt;

  always_comb begin
    case (mf_sel_e'(sel))
      MF_GPO:   nxt = ~gpo;
      MF_BAUD:  nxt = ~tick;
      MF_RXRDY: nxt = ~rxrdy;
      default:  nxt = 1'b1;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) mf_n <= 1'b1;
    else     mf_n <= nxt;
  end
endmodule

// File: rtl/duart_host_regs.sv
module duart_host_regs
  import duart_host_pkg::*;
#(
  parameter int    NCH         = 2,
  parameter int    SYNC_STAGES = 2,
  parameter byte_t ID_CODE     = 8'h02,
  parameter byte_t REV_CODE    = 8'h01,
  localparam int   CHW         = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_cs_n,
  input  logic [CHW-1:0] bus_chsel,
  input  logic           bus_rd_n,
  input  logic           bus_wr_n,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  input  logic [NCH-1:0] baud_tick,
  input  logic [NCH-1:0] rx_ready,
  output logic [NCH-1:0] mf_n
);
  logic wr_prev, wr_rise, wr_fall;
  logic rd_prev, rd_rise, rd_fall;

  duart_strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
    .clk(clk), .rst(rst), .strobe_n(bus_wr_n),
    .prev_n(wr_prev), .rise(wr_rise), .fall(wr_fall)
  );

  duart_strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
    .clk(clk), .rst(rst), .strobe_n(bus_rd_n),
    .prev_n(rd_prev), .rise(rd_rise), .fall(rd_fall)
  );

  chan_regs_t           regs [NCH];
  logic [NCH-1:0]       wr_en;
  logic [NCH-1:0][1:0]  mf_sel;
  logic [NCH-1:0]       gpo_bit;
  logic [NCH-1:0][DW-1:0] line_v;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign wr_en[g] = wr_rise & ~bus_cs_n & (bus_chsel == CHW'(g));

    duart_chan_regs u_regs (
      .clk(clk), .rst(rst), .wr_en(wr_en[g]),
      .addr(bus_addr), .wdata(bus_wdata), .regs(regs[g])
    );

    assign mf_sel[g]  = regs[g].alt_fn[SEL_LSB +: 2];
    assign gpo_bit[g] = regs[g].modem_out[GPO_BIT];
    assign line_v[g]  = regs[g].line_ctl;

    duart_mf_drive u_mf (
      .clk(clk), .rst(rst), .sel(mf_sel[g]), .gpo(gpo_bit[g]),
      .tick(baud_tick[g]), .rxrdy(rx_ready[g]), .mf_n(mf_n[g])
    );
  end

  byte_t rd_word;
  assign rd_word = read_mux(regs[bus_chsel], bus_addr, ID_CODE, REV_CODE);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)                       bus_rdata <= '0;
    else if (rd_fall && !bus_cs_n) bus_rdata <= rd_word;
  end

  logic unused_edges;
  assign unused_edges = wr_prev ^ wr_fall ^ rd_rise;
endmodule

// File: rtl/duart_host_regs_chk.sv
module duart_host_regs_chk #(
  parameter int NCH = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 rd_prev,
  input logic                 wr_rise,
  input logic [7:0]           bus_rdata,
  input logic [NCH-1:0][1:0]  mf_sel,
  input logic [NCH-1:0]       gpo_bit,
  input logic [NCH-1:0][7:0]  line_v,
  input logic [NCH-1:0]       baud_tick,
  input logic [NCH-1:0]       rx_ready,
  input logic [NCH-1:0]       mf_n
);
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rd_prev && !$past(rd_prev)) |-> $stable(bus_rdata)); // R4

  for (genvar c = 0; c < NCH; c++) begin : g_c
    AST_GPO_PASS: assert property (@(posedge clk) disable iff (rst)
      (mf_sel[c] == 2'b00) |=> (mf_n[c] == !$past(gpo_bit[c]))); // R8
    AST_BAUD_PASS: assert property (@(posedge clk) disable iff (rst)
      (mf_sel[c] == 2'b01) |=> (mf_n[c] == !$past(baud_tick[c]))); // R8
    AST_RXRDY_PASS: assert property (@(posedge clk) disable iff (rst)
      (mf_sel[c] == 2'b10) |=> (mf_n[c] == !$past(rx_ready[c]))); // R9
    AST_RSVD_IDLE: assert property (@(posedge clk) disable iff (rst)
      (mf_sel[c] == 2'b11) |=> mf_n[c]); // R10
    AST_LINE_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
      !$stable(line_v[c]) |-> $past(wr_rise)); // R2
    AST_ALT_KEYED: assert property (@(posedge clk) disable iff (rst)
      !$stable(mf_sel[c]) |-> ($past(line_v[c]) == 8'hBF)); // R6
  end
endmodule

bind duart_host_regs duart_host_regs_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .rd_prev(rd_prev), .wr_rise(wr_rise),
  .bus_rdata(bus_rdata), .mf_sel(mf_sel), .gpo_bit(gpo_bit),
  .line_v(line_v), .baud_tick(baud_tick), .rx_ready(rx_ready), .mf_n(mf_n)
);

// File: tb/sim_duart_host_regs.sv
`timescale 1ns/1ps
module sim_duart_host_regs;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, chsel = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] mf_n;
  logic [7:0] lfsr = 8'h5A;
  logic [1:0] baud_tick, rx_ready;

  int n_chk = 0, n_fail = 0;
  bit done = 0, cmp_on = 0;

  int m_lo[2], m_hi[2], m_line[2], m_alt[2], m_modem[2], m_scr[2];
  logic [1:0] exp_mf = 2'b11;

  always #2.5 clk = ~clk;

  assign baud_tick = lfsr[1:0];
  assign rx_ready  = lfsr[4:3];

  duart_host_regs u0 (
    .clk(clk), .rst(rst), .bus_cs_n(cs_n), .bus_chsel(chsel),
    .bus_rd_n(rd_n), .bus_wr_n(wr_n), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .baud_tick(baud_tick), .rx_ready(rx_ready), .mf_n(mf_n)
  );

  always @(negedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic model_mf(int ch);
    case ((m_alt[ch] >> 1) & 3)
      0: return !m_modem[ch][3];
      1: return !baud_tick[ch];
      2: return !rx_ready[ch];
      default: return 1'b1;
    endcase
  endfunction

  function automatic int model_read(int ch, int a);
    bit zero = (m_lo[ch] == 0) && (m_hi[ch] == 0);
    bit dl = m_line[ch][7];
    case (a)
      0: return dl ? (zero ? 1 : m_lo[ch]) : 0;
      1: return dl ? (zero ? 2 : m_hi[ch]) : 0;
      2: return (m_line[ch] == 'hBF) ? m_alt[ch] : 0;
      3: return m_line[ch];
      4: return m_modem[ch];
      7: return m_scr[ch];
      default: return 0;
    endcase
  endfunction

  task automatic model_write(int ch, int a, int d);
    case (a)
      0: if (m_line[ch][7]) m_lo[ch] = d;
      1: if (m_line[ch][7]) m_hi[ch] = d;
      2: if (m_line[ch] == 'hBF) m_alt[ch] = d;
      3: m_line[ch] = d;
      4: m_modem[ch] = d;
      7: m_scr[ch] = d;
      default: ;
    endcase
  endtask

  task automatic model_clear();
    for (int c = 0; c < 2; c++) begin
      m_lo[c] = 0; m_hi[c] = 0; m_line[c] = 0; m_alt[c] = 0; m_modem[c] = 0; m_scr[c] = 0;
    end
  endtask

  // per-cycle model of the multifunction pins
  always @(posedge clk) begin
    if (rst) exp_mf <= 2'b11;
    else for (int c = 0; c < 2; c++) exp_mf[c] <= model_mf(c);
  end

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      for (int c = 0; c < 2; c++) begin
        case ((m_alt[c] >> 1) & 3)
          0, 1: chk("R8 mf_n per cycle", mf_n[c], exp_mf[c]);
          2:    chk("R9 mf_n per cycle", mf_n[c], exp_mf[c]);
          default: chk("R10 mf_n per cycle", mf_n[c], exp_mf[c]);
        endcase
      end
    end
  end

  task automatic bus_wr(int ch, int a, int d);
    @(negedge clk);
    cs_n = 0; chsel = ch[0]; addr = a[2:0]; wdata = d[7:0]; wr_n = 0;
    repeat (2) @(negedge clk);
    wr_n = 1;
    repeat (3) @(negedge clk);
    model_write(ch, a, d);
    cs_n = 1;
  endtask

  task automatic bus_rd(int ch, int a, string tag);
    @(negedge clk);
    cs_n = 0; chsel = ch[0]; addr = a[2:0]; rd_n = 0;
    repeat (3) @(negedge clk);
    chk(tag, rdata, model_read(ch, a));
    rd_n = 1;
    repeat (3) @(negedge clk);
    cs_n = 1;
  endtask

  initial begin
    model_clear();
    repeat (4) @(negedge clk);
    chk("R11 rdata after reset", rdata, 0);
    chk("R11 mf_n after reset", mf_n, 2'b11);
    rst = 0;
    cmp_on = 1;
    bus_rd(0, 3, "R11 line ctl cleared");
    bus_rd(1, 7, "R11 scratch B cleared");

    bus_wr(0, 3, 'h80);
    bus_rd(0, 1, "R7 id byte");
    bus_rd(0, 0, "R7 revision byte");

    // R4 load timing: previous read returned 0x01
    @(negedge clk);
    cs_n = 0; chsel = 0; addr = 3; rd_n = 0;
    repeat (2) @(negedge clk);
    chk("R4 rdata before load edge", rdata, 'h01);
    @(negedge clk);
    chk("R4 rdata at load edge", rdata, 'h80);
    rd_n = 1;
    repeat (3) @(negedge clk);
    chk("R4 rdata held after strobe", rdata, 'h80);
    cs_n = 1;

    bus_wr(0, 0, 'h34);
    bus_rd(0, 1, "R5 high byte real when low nonzero");
    bus_rd(0, 0, "R5 low byte");
    bus_wr(0, 1, 'h12);
    bus_rd(0, 1, "R5 high byte");
    bus_wr(0, 3, 'h03);
    bus_rd(0, 0, "R5 hidden low byte reads zero");
    bus_rd(0, 1, "R5 hidden high byte reads zero");
    bus_wr(0, 0, 'h55);
    bus_wr(0, 3, 'h80);
    bus_rd(0, 0, "R5 hidden write ignored");

    bus_wr(0, 7, 'hA5);
    bus_rd(0, 7, "R3 scratch");
    bus_wr(0, 5, 'h77);
    bus_rd(0, 5, "R3 unused address reads zero");
    bus_rd(0, 4, "R3 modem byte");
    bus_rd(0, 3, "R3 line ctl");

    bus_wr(0, 3, 'h03);
    bus_wr(0, 2, 'h04);
    bus_rd(0, 2, "R6 alt hidden");
    bus_wr(0, 3, 'hBF);
    bus_rd(0, 2, "R6 alt ignored when locked");
    bus_wr(0, 2, 'h04);
    bus_rd(0, 2, "R6 alt readable with key");
    repeat (30) @(negedge clk);            // R9 via per-cycle compare
    bus_wr(0, 2, 'h02);
    repeat (30) @(negedge clk);            // R8 baud via per-cycle compare
    bus_wr(0, 2, 'h06);
    repeat (2) @(negedge clk);
    chk("R10 reserved select idle high", mf_n[0], 1);
    bus_wr(0, 2, 'h00);
    bus_wr(0, 4, 'h08);
    @(negedge clk);
    chk("R8 general output driven low", mf_n[0], 0);

    // R2 commit timing on channel B
    @(negedge clk);
    cs_n = 0; chsel = 1; addr = 4; wdata = 'h08; wr_n = 0;
    repeat (2) @(negedge clk);
    wr_n = 1;
    repeat (3) @(negedge clk);
    chk("R2 pin before commit visible", mf_n[1], 1);
    model_write(1, 4, 'h08);
    @(negedge clk);
    chk("R2 pin after commit", mf_n[1], 0);
    cs_n = 1;

    bus_wr(1, 7, 'h3C);
    bus_rd(1, 7, "R12 scratch B");
    bus_rd(0, 7, "R12 scratch A untouched");
    bus_rd(1, 3, "R12 line ctl B untouched");

    // R1 deselected write and read
    @(negedge clk);
    cs_n = 1; chsel = 0; addr = 7; wdata = 'hEE; wr_n = 0;
    repeat (2) @(negedge clk);
    wr_n = 1;
    repeat (4) @(negedge clk);
    bus_rd(0, 7, "R1 deselected write ignored");
    @(negedge clk);
    cs_n = 1; addr = 3; rd_n = 0;
    repeat (4) @(negedge clk);
    chk("R1 deselected read keeps rdata", rdata, 'hA5);
    rd_n = 1;
    repeat (3) @(negedge clk);

    // R11 reset mid-run
    @(negedge clk);
    rst = 1;
    model_clear();
    repeat (2) @(negedge clk);
    chk("R11 rdata cleared by reset", rdata, 0);
    chk("R11 mf_n high in reset", mf_n, 2'b11);
    rst = 0;
    bus_rd(0, 7, "R11 scratch cleared");
    bus_wr(0, 3, 'h80);
    bus_rd(0, 1, "R7 id after reset");

    repeat (5) @(negedge clk);
    done = 1;
  end

  initial begin
    while (!done && n_chk >= 0) begin
      @(posedge clk);
      if ($time > 100000ns && !done) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        done = 1;
      end
    end
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule